// File: doc/BRIEF.md
# Physical Register Reference Counter

This block keeps a small counter for every physical register of an out-of-order core whose renamer can eliminate moves, so that one physical register may back several architectural destinations at once. Each rename-time allocation adds one reference to the named register. Each release at retirement (the old mapping of a committed destination) removes one. A register is handed back to the free list only when its last reference disappears.

Two counter sets are held. The speculative set follows rename allocations and retirement releases. The architectural set follows only retirement: new destinations of committed instructions and released old mappings. On a pipeline redirect the speculative set is overwritten with the architectural one, so references held by squashed instructions vanish in one cycle.

A freed event is found in the same cycle as the update that empties a counter, and is held in a flop, so the free list sees a one-hot-per-register strobe vector one cycle later.

Top module: `refcnt_table`

## Requirements
- R1: Out of reset the registers numbered below RESET_LIVE hold one reference and all others hold none, and `freed_o` is all zeros.
- R2: Every valid allocation port naming register p adds one to p's speculative count.
- R3: Every valid release port naming register p subtracts one from both p's speculative and p's architectural count.
- R4: Bit p of `freed_o` rises only when p's speculative count moves from a non-zero value to exactly zero through that cycle's allocations and releases.
- R5: The freed bit appears on the clock edge that follows the emptying update and stays high for just that one cycle unless p empties again.
- R6: When several ports name the same register in one cycle, only the net sum of increments and decrements is applied, so a register with one reference that is allocated and released in the same cycle is not freed.
- R7: Architectural counts change only through valid commit ports (one addition per port naming p) and valid release ports; allocations never touch them.
- R8: While `redirect_i` is high, each speculative count is loaded with the architectural count as updated by that same cycle's commits and releases, and that cycle's allocations are discarded.
- R9: A release that empties a speculative count in a redirect cycle is still reported as freed.
- R10: No count ever exceeds MAX_REFS or drops below zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| alloc_vld_i | input | ALLOC_W | Per-port valid of rename-time allocations |
| alloc_preg_i | input | ALLOC_W x PW | Register named by each allocation port |
| cmt_vld_i | input | CMT_W | Per-port valid of committed new destinations |
| cmt_preg_i | input | CMT_W x PW | Register named by each commit port |
| rel_vld_i | input | REL_W | Per-port valid of retirement releases |
| rel_preg_i | input | REL_W x PW | Register named by each release port |
| redirect_i | input | 1 | Restore speculative counts from architectural ones |
| freed_o | output | NUM_PREGS | Registered per-register freed strobe, bit p = register p |

## Verification
Directed patterns separate the cases a faulty counter would merge: a single release of a reset-live register, two allocations of one register in one cycle followed by two single releases (only the second frees), an allocation and a release of one register in the same cycle (no free), and redirects with and without concurrent allocations or releases whose outcome is visible only through a later release freeing or not. A long random phase then mixes legal allocations, commits, releases and redirects over a narrow register range so port collisions are frequent, and every cycle the whole freed vector is compared with a model's prediction.

// File: rtl/refcnt_pkg.sv
package refcnt_pkg;
  // bits needed for a counter that reaches max_val
  function automatic int cnt_width(input int max_val);
    return (max_val < 2) ? 1 : $clog2(max_val + 1);
  endfunction
endpackage

// File: rtl/refcnt_tally.sv
// Counts, per physical register, how many valid ports name it this cycle.
module refcnt_tally #(
  parameter int NUM_PREGS = 64,
  parameter int PORTS     = 4,
  parameter int PW        = 6,
  parameter int TW        = 3
) (
  input  logic [PORTS-1:0]                 vld_i,
  input  logic [PORTS-1:0][PW-1:0]         preg_i,
  output logic [NUM_PREGS-1:0][TW-1:0]     hits_o
);
  for (genvar g = 0; g < NUM_PREGS; g++) begin : g_reg
    logic [TW-1:0] acc;
    always_comb begin
      acc = '0;
      for (int k = 0; k < PORTS; k++) begin
        if (vld_i[k] && (preg_i[k] == PW'(g))) acc = acc + TW'(1);
      end
    end
    assign hits_o[g] = acc;
  end
endmodule

// File: rtl/refcnt_bank.sv
// One counter set: net update, optional bulk load, reset pattern.
module refcnt_bank #(
  parameter int NUM_PREGS  = 64,
  parameter int CW         = 4,
  parameter int IW         = 3,
  parameter int DW         = 3,
  parameter int SW         = 12,
  parameter int RESET_LIVE = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_PREGS-1:0][IW-1:0]  inc_i,
  input  logic [NUM_PREGS-1:0][DW-1:0]  dec_i,
  input  logic                          load_i,
  input  logic [NUM_PREGS-1:0][CW-1:0]  load_val_i,
  output logic [NUM_PREGS-1:0][CW-1:0]  cnt_o,
  output logic [NUM_PREGS-1:0][SW-1:0]  sum_o,
  output logic [NUM_PREGS-1:0][CW-1:0]  nxt_o
);
  for (genvar g = 0; g < NUM_PREGS; g++) begin : g_cnt
    localparam logic [CW-1:0] RST_VAL = (g < RESET_LIVE) ? CW'(1) : '0;
    logic          en;
    logic [CW-1:0] nxt;
    logic [CW-1:0] q;

    always_comb begin
      sum_o[g] = SW'(q) + SW'(inc_i[g]) - SW'(dec_i[g]);
      nxt      = load_i ? load_val_i[g] : sum_o[g][CW-1:0];
      en       = load_i || (inc_i[g] != '0) || (dec_i[g] != '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= RST_VAL;
      else if (en) q <= nxt;
    end

    assign cnt_o[g] = q;
    assign nxt_o[g] = nxt;
  end
endmodule

// File: rtl/refcnt_table.sv
module refcnt_table #(
  parameter int NUM_PREGS  = 64,
  parameter int ALLOC_W    = 4,
  parameter int CMT_W      = 4,
  parameter int REL_W      = 4,
  parameter int MAX_REFS   = 15,
  parameter int RESET_LIVE = 32,
  localparam int PW        = $clog2(NUM_PREGS)
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [ALLOC_W-1:0]              alloc_vld_i,
  input  logic [ALLOC_W-1:0][PW-1:0]      alloc_preg_i,
  input  logic [CMT_W-1:0]                cmt_vld_i,
  input  logic [CMT_W-1:0][PW-1:0]        cmt_preg_i,
  input  logic [REL_W-1:0]                rel_vld_i,
  input  logic [REL_W-1:0][PW-1:0]        rel_preg_i,
  input  logic                            redirect_i,
  output logic [NUM_PREGS-1:0]            freed_o
);
  localparam int CW  = refcnt_pkg::cnt_width(MAX_REFS);
  localparam int AW  = $clog2(ALLOC_W + 1);
  localparam int CTW = $clog2(CMT_W + 1);
  localparam int RW  = $clog2(REL_W + 1);
  localparam int SW  = CW + AW + CTW + RW + 1;

  logic [NUM_PREGS-1:0][AW-1:0]  alloc_hits;
  logic [NUM_PREGS-1:0][CTW-1:0] cmt_hits;
  logic [NUM_PREGS-1:0][RW-1:0]  rel_hits;
  logic [NUM_PREGS-1:0][CW-1:0]  spec_cnt, arch_cnt, spec_nxt, arch_nxt;
  logic [NUM_PREGS-1:0][SW-1:0]  spec_sum, arch_sum;
  logic [NUM_PREGS-1:0]          freed_d, freed_q;

  refcnt_tally #(.NUM_PREGS(NUM_PREGS), .PORTS(ALLOC_W), .PW(PW), .TW(AW)) u_alloc_tally (
    .vld_i(alloc_vld_i), .preg_i(alloc_preg_i), .hits_o(alloc_hits));
  refcnt_tally #(.NUM_PREGS(NUM_PREGS), .PORTS(CMT_W), .PW(PW), .TW(CTW)) u_cmt_tally (
    .vld_i(cmt_vld_i), .preg_i(cmt_preg_i), .hits_o(cmt_hits));
  refcnt_tally #(.NUM_PREGS(NUM_PREGS), .PORTS(REL_W), .PW(PW), .TW(RW)) u_rel_tally (
    .vld_i(rel_vld_i), .preg_i(rel_preg_i), .hits_o(rel_hits));

  // architectural set: commits add, releases remove, never loaded
  refcnt_bank #(.NUM_PREGS(NUM_PREGS), .CW(CW), .IW(CTW), .DW(RW), .SW(SW),
                .RESET_LIVE(RESET_LIVE)) u_arch (
    .clk(clk), .rst_n(rst_n), .inc_i(cmt_hits), .dec_i(rel_hits),
    .load_i(1'b0), .load_val_i('0),
    .cnt_o(arch_cnt), .sum_o(arch_sum), .nxt_o(arch_nxt));

  // speculative set: allocations add, releases remove, redirect reloads
  refcnt_bank #(.NUM_PREGS(NUM_PREGS), .CW(CW), .IW(AW), .DW(RW), .SW(SW),
                .RESET_LIVE(RESET_LIVE)) u_spec (
    .clk(clk), .rst_n(rst_n), .inc_i(alloc_hits), .dec_i(rel_hits),
    .load_i(redirect_i), .load_val_i(arch_nxt),
    .cnt_o(spec_cnt), .sum_o(spec_sum), .nxt_o(spec_nxt));

  // emptying is judged on the update path, independent of a reload
  always_comb begin
    for (int p = 0; p < NUM_PREGS; p++) begin
      freed_d[p] = (spec_cnt[p] != '0) && (spec_sum[p] == '0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) freed_q <= '0;
    else        freed_q <= freed_d;
  end

  assign freed_o = freed_q;
endmodule

// File: rtl/refcnt_table_chk.sv
module refcnt_table_chk #(
  parameter int NUM_PREGS = 64,
  parameter int CW        = 4,
  parameter int SW        = 12,
  parameter int MAX_REFS  = 15,
  parameter int CMT_W     = 4,
  parameter int REL_W     = 4
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          redirect_i,
  input logic [CMT_W-1:0]              cmt_vld_i,
  input logic [REL_W-1:0]              rel_vld_i,
  input logic [NUM_PREGS-1:0]          freed_o,
  input logic [NUM_PREGS-1:0][CW-1:0]  spec_cnt,
  input logic [NUM_PREGS-1:0][CW-1:0]  arch_cnt,
  input logic [NUM_PREGS-1:0][SW-1:0]  spec_sum,
  input logic [NUM_PREGS-1:0][SW-1:0]  arch_sum
);
  AST_ARCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cmt_vld_i == '0 && rel_vld_i == '0) |=> $stable(arch_cnt)); // R7

  AST_REDIRECT_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_i |=> (spec_cnt == arch_cnt)); // R8

  for (genvar g = 0; g < NUM_PREGS; g++) begin : g_chk
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      ($signed(spec_sum[g]) <= MAX_REFS) && ($signed(arch_sum[g]) <= MAX_REFS)); // R10
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      ($signed(spec_sum[g]) >= 0) && ($signed(arch_sum[g]) >= 0)); // R10
    AST_FREED_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      freed_o[g] |-> (spec_cnt[g] == '0)); // R4
    AST_FREED_WAS_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
      freed_o[g] |-> ($past(spec_cnt[g]) != '0)); // R5
  end
endmodule

bind refcnt_table refcnt_table_chk #(
  .NUM_PREGS(NUM_PREGS), .CW(CW), .SW(SW), .MAX_REFS(MAX_REFS),
  .CMT_W(CMT_W), .REL_W(REL_W)
) u_refcnt_chk (
  .clk(clk), .rst_n(rst_n), .redirect_i(redirect_i),
  .cmt_vld_i(cmt_vld_i), .rel_vld_i(rel_vld_i), .freed_o(freed_o),
  .spec_cnt(spec_cnt), .arch_cnt(arch_cnt),
  .spec_sum(spec_sum), .arch_sum(arch_sum)
);

// File: tb/test_refcnt_table.sv
`timescale 1ns/1ps
module test_refcnt_table;
  localparam int N    = 64;
  localparam int AWP  = 4;
  localparam int CWP  = 4;
  localparam int RWP  = 4;
  localparam int MAXR = 15;
  localparam int LIVE = 32;
  localparam int PW   = $clog2(N);

  typedef struct {
    logic [N-1:0] vec;
    string        tag;
  } exp_t;

  logic                      clk = 1'b0;
  logic                      rst_n;
  logic [AWP-1:0]            s_av;
  logic [AWP-1:0][PW-1:0]    s_ap;
  logic [CWP-1:0]            s_cv;
  logic [CWP-1:0][PW-1:0]    s_cp;
  logic [RWP-1:0]            s_rv;
  logic [RWP-1:0][PW-1:0]    s_rp;
  logic                      s_redir;
  logic [N-1:0]              freed_o;

  int spec_m[N];
  int arch_m[N];
  exp_t q[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  refcnt_table #(.NUM_PREGS(N), .ALLOC_W(AWP), .CMT_W(CWP), .REL_W(RWP),
                 .MAX_REFS(MAXR), .RESET_LIVE(LIVE)) i_refcnt_table (
    .clk(clk), .rst_n(rst_n),
    .alloc_vld_i(s_av), .alloc_preg_i(s_ap),
    .cmt_vld_i(s_cv), .cmt_preg_i(s_cp),
    .rel_vld_i(s_rv), .rel_preg_i(s_rp),
    .redirect_i(s_redir), .freed_o(freed_o));

  task automatic clr();
    s_av = '0; s_ap = '0; s_cv = '0; s_cp = '0;
    s_rv = '0; s_rp = '0; s_redir = 1'b0;
  endtask

  task automatic al(input int k, input int p); s_av[k] = 1'b1; s_ap[k] = PW'(p); endtask
  task automatic cm(input int k, input int p); s_cv[k] = 1'b1; s_cp[k] = PW'(p); endtask
  task automatic rl(input int k, input int p); s_rv[k] = 1'b1; s_rp[k] = PW'(p); endtask

  // driver: predict the freed vector of this cycle's update, update model, push
  task automatic drive(input string tag);
    exp_t e;
    int ia, ic, ir;
    e.tag = tag;
    for (int p = 0; p < N; p++) begin
      ia = 0; ic = 0; ir = 0;
      for (int k = 0; k < AWP; k++) if (s_av[k] && s_ap[k] == PW'(p)) ia++;
      for (int k = 0; k < CWP; k++) if (s_cv[k] && s_cp[k] == PW'(p)) ic++;
      for (int k = 0; k < RWP; k++) if (s_rv[k] && s_rp[k] == PW'(p)) ir++;
      e.vec[p] = (spec_m[p] != 0) && (spec_m[p] + ia - ir == 0);
      arch_m[p] = arch_m[p] + ic - ir;
      spec_m[p] = s_redir ? arch_m[p] : spec_m[p] + ia - ir;
    end
    q.push_back(e);
    @(negedge clk);
    clr();
  endtask

  // monitor: one comparison per cycle in which an expectation is pending
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        e = q.pop_front();
        checks++;
        if (freed_o !== e.vec) begin
          errors++;
          $display("FAIL %s: freed_o=%h expected %h", e.tag, freed_o, e.vec);
        end
      end
    end
  end

  initial begin
    #800000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int pa[N], pc[N], pr[N];
    int p;
    clr();
    rst_n = 1'b0;
    for (int i = 0; i < N; i++) begin
      spec_m[i] = (i < LIVE) ? 1 : 0;
      arch_m[i] = spec_m[i];
    end
    repeat (3) @(negedge clk);
    checks++;
    if (freed_o !== '0) begin
      errors++;
      $display("FAIL R1: freed_o=%h expected %h", freed_o, {N{1'b0}});
    end
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R4: a reset-live register empties on one release
    rl(0, 3);                 drive("R1 R3 R4 release of reset-live reg 3");
    drive("R5 freed strobe lasts one cycle");
    // R2: allocate then commit and release old mapping
    al(0, 40);                drive("R2 alloc 40");
    cm(0, 40); rl(1, 7);      drive("R3 R7 commit 40 release 7");
    rl(2, 40);                drive("R2 R4 release 40 empties it");
    // R6: two ports allocate the same register in one cycle
    al(1, 41); al(3, 41);     drive("R6 double alloc 41");
    cm(0, 41); cm(2, 41);     drive("R7 double commit 41");
    rl(0, 41);                drive("R6 first release of 41 keeps it");
    rl(3, 41);                drive("R4 second release of 41 frees");
    // R6: allocate and release one register together, net zero
    al(2, 10); rl(1, 10);     drive("R6 alloc+release of 10 same cycle");
    cm(1, 10);                drive("R7 commit 10");
    rl(0, 10);                drive("R6 count of 10 still one, frees now");
    // R8: redirect drops speculative-only references
    al(0, 50);                drive("R2 alloc 50");
    al(0, 50);                drive("R2 alloc 50 again");
    cm(3, 50);                drive("R7 commit one of 50");
    s_redir = 1'b1;           drive("R8 redirect");
    rl(0, 50);                drive("R8 restored 50 frees on one release");
    // R8: allocation in the redirect cycle is discarded
    s_redir = 1'b1; al(1, 52); drive("R8 redirect with alloc 52");
    al(0, 52);                drive("R2 alloc 52");
    cm(0, 52);                drive("R7 commit 52");
    rl(0, 52);                drive("R8 discarded alloc leaves 52 at one");
    // R9: release emptying a register during redirect
    s_redir = 1'b1; rl(2, 12); drive("R9 redirect with release of 12");
    s_redir = 1'b1; rl(0, 13); rl(1, 14); al(2, 60); drive("R9 redirect two releases");

    // random legal traffic with frequent collisions
    for (int cyc = 0; cyc < 3000; cyc++) begin
      for (int i = 0; i < N; i++) begin pa[i] = 0; pc[i] = 0; pr[i] = 0; end
      for (int k = 0; k < AWP; k++) begin
        p = ($urandom_range(0, 7) == 0) ? $urandom_range(0, N-1) : $urandom_range(0, 15);
        if ($urandom_range(0, 1) == 1 && spec_m[p] + pa[p] < MAXR - 4) begin
          al(k, p); pa[p]++;
        end
      end
      for (int k = 0; k < CWP; k++) begin
        p = $urandom_range(0, 15);
        if (spec_m[p] - arch_m[p] - pc[p] > 0) begin cm(k, p); pc[p]++; end
      end
      for (int k = 0; k < RWP; k++) begin
        p = $urandom_range(0, 15);
        if ($urandom_range(0, 1) == 1 && arch_m[p] - pr[p] > 0) begin rl(k, p); pr[p]++; end
      end
      s_redir = ($urandom_range(0, 15) == 0);
      drive("R2 R3 R4 R6 R7 R8 R9 random traffic");
    end

    repeat (3) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule